// File: doc/BRIEF.md
# Dual-Channel Compare Timer (Physical and Virtual)

This per-core unit watches a free-running 64-bit system count supplied from outside. It raises timer events on two independent compare channels. Channel 0 is the physical channel and compares the raw count. Channel 1 is the virtual channel. It first subtracts a writable 64-bit offset from the count, so a hypervisor can hide the intervals in which a guest was descheduled. Both counts advance at the same rate, because both are derived from the same input.

Each channel holds a 64-bit compare value and a small control register, and drives its own level-sensitive interrupt line. The compare value can also be read and written as a signed 32-bit "time remaining" view. Software reaches every register through one synchronous port that carries a channel select and a register select. Read data appears on the cycle after the request. The interrupt identifiers of the two lines (29 for physical, 27 for virtual) are carried as parameters, for whoever wires the lines to an interrupt controller.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every channel has enable=0, mask=0 and compare=0, the virtual offset is 0, both interrupt lines are low, and a virtual count read returns the same value as the system count.
- R2: A read request (reg_en=1, reg_we=0) is sampled on a rising edge and its data is on reg_rdata after that edge. A count read (reg_sel=0) on channel 0 (reg_chan=0) returns sys_count.
- R3: A count read on channel 1 returns (sys_count - offset) modulo 2^64, so an offset above the count wraps to a large value.
- R4: Register select 4 is the offset. On channel 1 it is readable and writable. On channel 0 it reads 0 and writes to it change nothing.
- R5: The control register (reg_sel=3) holds bit0 enable, bit1 mask and bit2 status. Status is read-only, writes to bit2 are ignored, and bits above 2 read 0.
- R6: Status reads 1 exactly when enable is 1 and the channel count, taken as unsigned, is at least the compare value (reg_sel=1).
- R7: Each interrupt line is registered. One edge after its channel's state or count settles, it equals enable AND status AND NOT mask.
- R8: A read of the timer view (reg_sel=2) returns the low 32 bits of (compare - channel count), zero-extended.
- R9: A write of the timer view sets compare to the channel count plus the sign-extended low 32 bits of the write data.
- R10: An offset write alone re-evaluates the virtual compare, and the virtual interrupt line follows on the next edge.
- R11: A write to one channel leaves the other channel's registers and interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Shared free-running system count |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_chan | input | 1 | 0 = physical channel, 1 = virtual channel |
| reg_sel | input | 3 | 0 count, 1 compare, 2 timer view, 3 control, 4 offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| irq_phys | output | 1 | Physical channel interrupt level |
| irq_virt | output | 1 | Virtual channel interrupt level |

## Verification
A corrupted offset shows up at once in the virtual count and timer-view reads. It also moves the virtual interrupt edge to a different sys_count value, which becomes visible one cycle after the count crosses the compare value. A wrong compare value or control bit is exposed by the status bit in the very next control read, and by the interrupt line one edge later. The unsigned comparison is separated from a signed one by a compare value with the top bit set. Writes that leak between channels are caught by reading back the untouched channel and watching its interrupt line.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 64;
  localparam int TV_W  = 32;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT  = 3'd0,
    SEL_CMP    = 3'd1,
    SEL_TVAL   = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_OFFSET = 3'd4
  } reg_sel_e;

  localparam int CTL_EN  = 0;
  localparam int CTL_MSK = 1;
  localparam int CTL_ST  = 2;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int  CW         = 64,
  parameter int  TW         = 32,
  parameter bit  HAS_OFFSET = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] sys_count,
  input  logic          wr_en,
  input  logic [2:0]    sel,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] view,
  output logic          irq_q
);
  import tmr_pkg::*;

  logic [CW-1:0] cmp_q, offset_q, count, tval_full;
  logic          en_q, mask_q, status;
  logic          wr_cmp, wr_tval, wr_ctrl, wr_off;

  assign count     = sys_count - offset_q;
  assign status    = en_q && (count >= cmp_q);
  assign tval_full = cmp_q - count;

  assign wr_cmp  = wr_en && (sel == SEL_CMP);
  assign wr_tval = wr_en && (sel == SEL_TVAL);
  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_off  = wr_en && (sel == SEL_OFFSET) && HAS_OFFSET;

  always_comb begin
    case (sel)
      SEL_COUNT:  view = count;
      SEL_CMP:    view = cmp_q;
      SEL_TVAL:   view = {{(CW-TW){1'b0}}, tval_full[TW-1:0]};
      SEL_CTRL:   view = {{(CW-3){1'b0}}, status, mask_q, en_q};
      SEL_OFFSET: view = offset_q;
      default:    view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q    <= '0;
      offset_q <= '0;
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= status && !mask_q;
      if (wr_cmp)  cmp_q <= wdata;
      if (wr_tval) cmp_q <= count + {{(CW-TW){wdata[TW-1]}}, wdata[TW-1:0]};
      if (wr_ctrl) begin
        en_q   <= wdata[CTL_EN];
        mask_q <= wdata[CTL_MSK];
      end
      if (wr_off) offset_q <= wdata;
    end
  end

  // R5: control write lands in enable and mask
  a_r5_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    $past(wr_ctrl && !rst) |-> (en_q == $past(wdata[CTL_EN]) && mask_q == $past(wdata[CTL_MSK])));

  // R7: a disabled channel never raises its line on the next edge
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_q);

  // R7: a masked channel never raises its line on the next edge
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
    mask_q |=> !irq_q);

  // R9: timer-view write reads back as written while the count holds still
  a_r9_tval_roundtrip: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_tval && !rst) && $stable(sys_count)) |-> (tval_full[TW-1:0] == $past(wdata[TW-1:0])));
endmodule

// File: rtl/tmr_rdport.sv
module tmr_rdport #(
  parameter int NCH = 2,
  parameter int CW  = 64,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [CHW-1:0]           chan,
  input  logic [NCH-1:0][CW-1:0]   views,
  output logic [CW-1:0]            rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= views[chan];
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int PHYS_IRQ_ID = 29,
  parameter int VIRT_IRQ_ID = 27
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [tmr_pkg::CNT_W-1:0] sys_count,
  input  logic                    reg_en,
  input  logic                    reg_we,
  input  logic                    reg_chan,
  input  logic [tmr_pkg::SEL_W-1:0] reg_sel,
  input  logic [tmr_pkg::CNT_W-1:0] reg_wdata,
  output logic [tmr_pkg::CNT_W-1:0] reg_rdata,
  output logic                    irq_phys,
  output logic                    irq_virt
);
  import tmr_pkg::*;
  localparam int NCH = 2;

  logic [NCH-1:0][CNT_W-1:0] views;
  logic [NCH-1:0]            irqs;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_channel #(
      .CW(CNT_W), .TW(TV_W), .HAS_OFFSET(g == 1)
    ) u_ch (
      .clk       (clk),
      .rst       (rst),
      .sys_count (sys_count),
      .wr_en     (reg_en && reg_we && (reg_chan == g[0])),
      .sel       (reg_sel),
      .wdata     (reg_wdata),
      .view      (views[g]),
      .irq_q     (irqs[g])
    );
  end

  tmr_rdport #(.NCH(NCH), .CW(CNT_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (reg_en && !reg_we),
    .chan  (reg_chan),
    .views (views),
    .rdata (reg_rdata)
  );

  assign irq_phys = irqs[0];
  assign irq_virt = irqs[1];

  // R2: physical count read returns the system count of the request cycle
  a_r2_phys_count: assert property (@(posedge clk) disable iff (rst)
    $past(reg_en && !reg_we && !reg_chan && reg_sel == SEL_COUNT && !rst)
      |-> reg_rdata == $past(sys_count));

  // R4: physical offset reads as zero
  a_r4_phys_offset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(reg_en && !reg_we && !reg_chan && reg_sel == SEL_OFFSET && !rst)
      |-> reg_rdata == '0);
endmodule

// File: tb/dual_cmp_timer_test.sv
`timescale 1ns/1ps
module dual_cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] sys_count = 64'd1000;
  logic        reg_en = 1'b0, reg_we = 1'b0, reg_chan = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_phys, irq_virt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_cmp_timer uut (
    .clk(clk), .rst(rst), .sys_count(sys_count),
    .reg_en(reg_en), .reg_we(reg_we), .reg_chan(reg_chan), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_phys(irq_phys), .irq_virt(irq_virt)
  );

  localparam logic [2:0] S_CNT = 0, S_CMP = 1, S_TV = 2, S_CTL = 3, S_OFF = 4;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [2:0] sel, input logic [63:0] d);
    reg_en = 1; reg_we = 1; reg_chan = ch; reg_sel = sel; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic ch, input logic [2:0] sel, output logic [63:0] d);
    reg_en = 1; reg_we = 0; reg_chan = ch; reg_sel = sel;
    @(posedge clk); @(negedge clk);
    reg_en = 0;
    d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 irq_phys", {63'd0, irq_phys}, 64'd0);
    chk("R1 irq_virt", {63'd0, irq_virt}, 64'd0);
    rd(0, S_CTL, d); chk("R1 phys ctrl", d, 64'd0);
    rd(1, S_CTL, d); chk("R1 virt ctrl", d, 64'd0);
    rd(1, S_CMP, d); chk("R1 virt cmp", d, 64'd0);
    rd(1, S_OFF, d); chk("R1 virt offset", d, 64'd0);
    rd(1, S_CNT, d); chk("R1 virt count equals sys", d, 64'd1000);
  endtask

  task automatic t_counts();
    logic [63:0] d;
    sys_count = 64'h1234_5678_9ABC_DEF0;
    rd(0, S_CNT, d); chk("R2 phys count", d, 64'h1234_5678_9ABC_DEF0);
    sys_count = 64'h1000;
    wr(1, S_OFF, 64'h100);
    rd(1, S_OFF, d); chk("R4 virt offset readback", d, 64'h100);
    rd(1, S_CNT, d); chk("R3 virt count", d, 64'hF00);
    wr(1, S_OFF, 64'h2000);
    rd(1, S_CNT, d); chk("R3 virt count wraps", d, 64'hFFFF_FFFF_FFFF_F000);
    wr(0, S_OFF, 64'h55);
    rd(0, S_OFF, d); chk("R4 phys offset ignored", d, 64'd0);
    rd(0, S_CNT, d); chk("R4 phys count unshifted", d, 64'h1000);
  endtask

  task automatic t_ctrl_layout();
    logic [63:0] d;
    sys_count = 64'h5000;
    wr(0, S_CMP, 64'd0);
    wr(0, S_CTL, 64'hFFFF_FFFF_FFFF_FFF7);
    rd(0, S_CTL, d); chk("R5 ctrl all set, status from compare", d, 64'h7);
    wr(0, S_CMP, 64'h5064);
    wr(0, S_CTL, 64'h5);
    rd(0, S_CTL, d); chk("R5 status write ignored", d, 64'h1);
    wr(0, S_CTL, 64'h0);
  endtask

  task automatic t_compare_irq();
    logic [63:0] d;
    sys_count = 64'd499;
    wr(0, S_CMP, 64'd500);
    wr(0, S_CTL, 64'h1);
    settle();
    chk("R7 irq below compare", {63'd0, irq_phys}, 64'd0);
    rd(0, S_CTL, d); chk("R6 status below compare", d, 64'h1);
    sys_count = 64'd500; settle(); settle();
    chk("R7 irq at compare", {63'd0, irq_phys}, 64'd1);
    rd(0, S_CTL, d); chk("R6 status at compare", d, 64'h5);
    sys_count = 64'd501; settle(); settle();
    chk("R7 irq above compare", {63'd0, irq_phys}, 64'd1);
    wr(0, S_CTL, 64'h3); settle();
    chk("R7 irq masked", {63'd0, irq_phys}, 64'd0);
    rd(0, S_CTL, d); chk("R6 status while masked", d, 64'h7);
    wr(0, S_CTL, 64'h0); settle();
    rd(0, S_CTL, d); chk("R6 status disabled", d, 64'h0);
    chk("R7 irq disabled", {63'd0, irq_phys}, 64'd0);
    sys_count = 64'd1;
    wr(0, S_CMP, 64'h8000_0000_0000_0000);
    wr(0, S_CTL, 64'h1); settle();
    rd(0, S_CTL, d); chk("R6 unsigned compare", d, 64'h1);
    chk("R7 irq unsigned compare", {63'd0, irq_phys}, 64'd0);
    wr(0, S_CTL, 64'h0);
  endtask

  task automatic t_tval();
    logic [63:0] d;
    sys_count = 64'h1000;
    wr(1, S_OFF, 64'h10);
    wr(1, S_TV, 64'h20);
    rd(1, S_CMP, d); chk("R9 tval write positive", d, 64'h1010);
    rd(1, S_TV, d);  chk("R8 tval read positive", d, 64'h20);
    wr(1, S_TV, 64'hFFFF_FFF0);
    rd(1, S_CMP, d); chk("R9 tval write negative", d, 64'hFE0);
    rd(1, S_TV, d);  chk("R8 tval read negative", d, 64'hFFFF_FFF0);
    wr(1, S_CTL, 64'h1); settle();
    chk("R7 virt irq after tval", {63'd0, irq_virt}, 64'd1);
  endtask

  task automatic t_offset_reeval();
    sys_count = 64'h1000;
    wr(1, S_OFF, 64'd0);
    wr(1, S_CMP, 64'h1000);
    wr(1, S_CTL, 64'h1); settle();
    chk("R10 virt irq with zero offset", {63'd0, irq_virt}, 64'd1);
    wr(1, S_OFF, 64'd1);
    chk("R10 irq holds on write edge", {63'd0, irq_virt}, 64'd1);
    settle();
    chk("R10 irq drops after offset write", {63'd0, irq_virt}, 64'd0);
    wr(1, S_OFF, 64'd0); settle();
    chk("R10 irq returns after offset clear", {63'd0, irq_virt}, 64'd1);
  endtask

  task automatic t_independence();
    logic [63:0] d;
    sys_count = 64'h1000;
    wr(0, S_CMP, 64'h777);
    wr(0, S_CTL, 64'h1);
    wr(1, S_CTL, 64'h0);
    wr(1, S_CMP, 64'hFFFF_FFFF_FFFF_FFFF);
    settle();
    rd(0, S_CMP, d); chk("R11 phys cmp untouched", d, 64'h777);
    rd(0, S_CTL, d); chk("R11 phys ctrl untouched", d, 64'h5);
    chk("R11 irq_phys kept", {63'd0, irq_phys}, 64'd1);
    chk("R11 irq_virt off", {63'd0, irq_virt}, 64'd0);
    wr(0, S_CMP, 64'h2);
    rd(1, S_CMP, d); chk("R11 virt cmp untouched", d, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    t_reset();
    t_counts();
    t_ctrl_layout();
    t_compare_irq();
    t_tval();
    t_offset_reeval();
    t_independence();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule